// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a synchronous static RAM with a four-beat burst address generator. It holds `2**AW` words, each made of `LANES` byte lanes (32 bits with the defaults). The address parameter can be raised to 17 to reach 128K words. Every input is sampled on the rising clock edge except the output enable.

A transfer starts when either of two active-low address strobes loads an external address, together with the state of three chip enables. After that, an active-low advance input steps the two lowest address bits through the aligned group of four in linear order, wrapping as it goes. Holding advance high repeats the current address. At each edge the selected address is written, or, if no write is requested, read.

A global write stores every lane. A byte write stores only the lanes picked by the byte-select inputs. Read data comes from a register and is driven out as `q_out` with a separate drive-enable `q_drive`, so that the chip's pad ring can build the tri-state bus.

Top module: `sbsram_core`

## Requirements
- R1: A load occurs at an edge where `strb_ctl_n` is low, or where `strb_cpu_n` and `en_a_n` are both low. The device is then selected if `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A read at a selected edge presents that word on `q_out` with `q_drive`=1 during the next clock cycle, provided `out_en_n` is low.
- R2: While `en_a_n` is high, a low `strb_cpu_n` (with `strb_ctl_n` high) loads nothing. The address and the selection state carry on unchanged.
- R3: Changes of `en_a_n`, `en_b` or `en_c_n` between loads have no effect on selection. Reads keep being driven.
- R4: At an edge without a load, a low `adv_n` increments address bits [1:0] modulo 4 and leaves the upper bits unchanged. A burst loaded at offset 2 therefore visits offsets 2, 3, 0, 1.
- R5: At an edge without a load, a high `adv_n` keeps the address. The access repeats at the same word.
- R6: A low `wr_all_n` at a selected edge writes all lanes, whatever `wr_byte_n` and `lane_sel_n` are.
- R7: With `wr_all_n` high and `wr_byte_n` low, only the lanes `l` with `lane_sel_n[l]`=0 are written. Lane `l` is data bits [8l+7:8l]. All other lanes keep their contents.
- R8: `q_drive` is 0 whenever `out_en_n` is high, and it follows `out_en_n` without waiting for a clock edge.
- R9: In the cycle after an edge that selects the device from a deselected state, `q_drive` stays 0 even with `out_en_n` low.
- R10: A load with a chip enable inactive deselects the device. `q_drive` is 0 in the following cycles, and writes attempted at that edge or later while deselected change no memory word.
- R11: After reset the device is deselected and `q_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | AW | External word address |
| strb_cpu_n | input | 1 | Address strobe gated by `en_a_n`, active low |
| strb_ctl_n | input | 1 | Address strobe not gated, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | LANES | Per-lane byte select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data |
| q_out | output | LANES*LANE_W | Registered read data |
| q_drive | output | 1 | Drive enable for the data bus pads |

## Verification
Two functions can fall on the same edge: an address load together with a write, and a burst advance together with a byte write. In both cases the write must land on the address that is new at that edge, not on the old one. The bench provokes both by asserting a strobe or `adv_n` in the same cycle as `wr_all_n` or `wr_byte_n`. It then judges the outcome by reading every touched word back through a later burst and comparing it with a lane-merged reference array. A third overlap puts a selecting load right after a deselect with `out_en_n` low. Here the bench expects the mask cycle first and then the data on a suspended repeat.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CPU  = 2'd1,
    LD_CTL  = 2'd2
  } ld_src_t;

  // next offset inside the aligned group of four
  function automatic logic [1:0] burst_step(input logic [1:0] cnt, input logic adv_n);
    return adv_n ? cnt : cnt + 2'd1;
  endfunction

  // all three enables in their active state
  function automatic logic chip_on(input logic e_a_n, input logic e_b, input logic e_c_n);
    return !e_a_n && e_b && !e_c_n;
  endfunction

endpackage

// File: rtl/sbsram_addr_ctl.sv
module sbsram_addr_ctl
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_in,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  output logic [AW-1:0] acc_addr,
  output logic          acc_sel,
  output logic          load,
  output logic          wake
);

  ld_src_t       src;
  logic [AW-1:0] addr_q;
  logic          sel_q;

  always_comb begin
    if (!strb_ctl_n)                 src = LD_CTL;
    else if (!strb_cpu_n && !en_a_n) src = LD_CPU;
    else                             src = LD_NONE;
  end

  assign load     = (src != LD_NONE);
  assign acc_addr = load ? a_in : {addr_q[AW-1:2], burst_step(addr_q[1:0], adv_n)};
  assign acc_sel  = load ? chip_on(en_a_n, en_b, en_c_n) : sel_q;
  assign wake     = acc_sel && !sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      addr_q <= acc_addr;
      sel_q  <= acc_sel;
    end
  end

  // R4: advance increments the offset and keeps the group
  a_r4_wrap_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> (addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1))
                          && (addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

  // R5: suspend holds the address
  a_r5_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(addr_q));

  // R3: selection changes only at a load
  a_r3_sel_only_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));

  // R2: gated strobe with en_a_n high loads nothing
  a_r2_cpu_strobe_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && en_a_n && strb_ctl_n && adv_n) |=> ($stable(addr_q) && $stable(sel_q)));

endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             acc_sel,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             is_write
);

  assign is_write = !wr_all_n || !wr_byte_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = acc_sel && (!wr_all_n || (!wr_byte_n && !lane_sel_n[l]));
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      if (rd_en)      rd_q      <= mem[addr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           a_in,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] q_out,
  output logic                    q_drive
);

  logic [AW-1:0]    acc_addr;
  logic             acc_sel;
  logic             load;
  logic             wake;
  logic [LANES-1:0] lane_we;
  logic             is_write;
  logic             rd_en;
  logic             rd_valid_q;
  logic             first_q;

  sbsram_addr_ctl #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .acc_addr(acc_addr), .acc_sel(acc_sel), .load(load), .wake(wake)
  );

  sbsram_wr_decode #(.LANES(LANES)) u_wdec (
    .acc_sel(acc_sel), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .lane_we(lane_we), .is_write(is_write)
  );

  assign rd_en = acc_sel && !is_write;

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .lane_we(lane_we), .rd_en(rd_en), .addr(acc_addr),
    .wdata(d_in), .rdata(q_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      first_q    <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      first_q    <= wake;
    end
  end

  assign q_drive = !out_en_n && rd_valid_q && !first_q;

  // R8: output enable high always releases the bus
  a_r8_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !q_drive);

  // R9: first cycle out of deselect is masked
  a_r9_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !q_drive);

  // R10: a deselecting load releases the bus and blocks writes
  a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !acc_sel) |=> !q_drive);
  a_r10_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_sel |-> (lane_we == '0));

  // R6: global write reaches every lane
  a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n && acc_sel) |-> (lane_we == '1));

endmodule

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;

  localparam int AW = 8;
  localparam int LANES = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, strb_cpu_n, strb_ctl_n, adv_n, en_a_n, en_b, en_c_n;
  logic wr_all_n, wr_byte_n, out_en_n;
  logic [LANES-1:0] lane_sel_n;
  logic [AW-1:0] a_in;
  logic [DW-1:0] d_in, q_out;
  logic q_drive;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] model [256];

  sbsram_core #(.AW(AW), .LANES(LANES), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .d_in(d_in), .q_out(q_out), .q_drive(q_drive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = '1;
  endtask

  task automatic enables(input logic on);
    en_a_n = 1'b0; en_b = on; en_c_n = 1'b0;
  endtask

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] base, input int k);
    logic [1:0] off;
    off = 2'(int'(base[1:0]) + k);
    return {base[AW-1:2], off};
  endfunction

  // burst of full writes, load and first write on the same edge
  task automatic wr_burst(input logic [AW-1:0] base, input int n, input logic [DW-1:0] seed);
    for (int k = 0; k < n; k++) begin
      idle();
      if (k == 0) begin strb_ctl_n = 1'b0; a_in = base; end
      else adv_n = 1'b0;
      wr_all_n = 1'b0;
      d_in = seed + DW'(k);
      tick();
      model[beat(base, k)] = seed + DW'(k);
    end
    idle();
  endtask

  // burst read from a selected state
  task automatic rd_burst(input string req, input logic [AW-1:0] base, input int n);
    out_en_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      idle();
      if (k == 0) begin strb_ctl_n = 1'b0; a_in = base; end
      else adv_n = 1'b0;
      tick();
      chk(req, {31'd0, q_drive}, 32'd1);
      chk(req, q_out, model[beat(base, k)]);
    end
    idle();
  endtask

  task automatic t_reset;
    rst_n = 1'b0; idle(); enables(1'b1); out_en_n = 1'b0; a_in = '0; d_in = '0;
    tick(); tick(); tick();
    chk("R11 reset drive", {31'd0, q_drive}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R11 idle after reset", {31'd0, q_drive}, 32'd0);
  endtask

  task automatic t_burst_wrap;
    wr_burst(8'h10, 4, 32'hA0A0_0000);
    rd_burst("R4 wrap from offset 2", 8'h12, 4);
    rd_burst("R1 load and read", 8'h10, 1);
  endtask

  task automatic t_suspend;
    wr_burst(8'h20, 4, 32'h5150_0000);
    rd_burst("R5 load", 8'h20, 1);
    for (int k = 0; k < 2; k++) begin
      idle(); tick();
      chk("R5 suspend repeat", q_out, model[8'h20]);
    end
    adv_n = 1'b0; tick(); idle();
    chk("R5 advance after suspend", q_out, model[8'h21]);
  endtask

  task automatic t_bytes;
    wr_burst(8'h30, 1, 32'h1122_3344);
    idle(); strb_ctl_n = 1'b0; a_in = 8'h30; wr_byte_n = 1'b0;
    lane_sel_n = 4'b1010; d_in = 32'hAABB_CCDD; tick(); idle();
    model[8'h30] = 32'h11BB_33DD;
    rd_burst("R7 lanes 0 and 2 written", 8'h30, 1);
    chk("R7 merged value", model[8'h30], 32'h11BB_33DD);
    // advance and byte write on the same edge
    idle(); adv_n = 1'b0; wr_byte_n = 1'b0; lane_sel_n = 4'b0111;
    d_in = 32'h7700_0000; tick(); idle();
    model[8'h31] = 32'h7700_0000 | (model[8'h31] & 32'h00FF_FFFF);
    rd_burst("R7 lane 3 at advanced address", 8'h31, 1);
    // global write overrides byte selects
    idle(); strb_ctl_n = 1'b0; a_in = 8'h32; wr_all_n = 1'b0; wr_byte_n = 1'b0;
    lane_sel_n = 4'b1110; d_in = 32'hCAFE_F00D; tick(); idle();
    model[8'h32] = 32'hCAFE_F00D;
    rd_burst("R6 global write with byte selects", 8'h32, 1);
    idle(); strb_ctl_n = 1'b0; a_in = 8'h33; wr_all_n = 1'b0;
    d_in = 32'h0BAD_BEEF; tick(); idle();
    model[8'h33] = 32'h0BAD_BEEF;
    rd_burst("R6 global write alone", 8'h33, 1);
  endtask

  task automatic t_cpu_strobe;
    rd_burst("R1 ctl strobe", 8'h10, 1);
    idle(); strb_cpu_n = 1'b0; en_a_n = 1'b1; a_in = 8'h30; tick(); idle(); enables(1'b1);
    chk("R2 blocked strobe keeps address", q_out, model[8'h10]);
    chk("R2 still driving", {31'd0, q_drive}, 32'd1);
    idle(); strb_cpu_n = 1'b0; a_in = 8'h11; tick(); idle();
    chk("R1 cpu strobe loads", q_out, model[8'h11]);
  endtask

  task automatic t_enable_hold;
    rd_burst("R3 load", 8'h20, 1);
    en_a_n = 1'b1; en_b = 1'b0; en_c_n = 1'b1;
    tick();
    chk("R3 still selected", {31'd0, q_drive}, 32'd1);
    chk("R3 data", q_out, model[8'h20]);
    adv_n = 1'b0; tick(); idle();
    chk("R3 advance unaffected", q_out, model[8'h21]);
    enables(1'b1);
  endtask

  task automatic t_oe;
    rd_burst("R8 load", 8'h22, 1);
    out_en_n = 1'b1; #1;
    chk("R8 released", {31'd0, q_drive}, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R8 restored", {31'd0, q_drive}, 32'd1);
  endtask

  task automatic t_deselect_and_wake;
    idle(); strb_ctl_n = 1'b0; en_b = 1'b0; a_in = 8'h12;
    wr_all_n = 1'b0; d_in = 32'hDEAD_0001; tick(); idle(); enables(1'b1);
    chk("R10 drive off after deselect", {31'd0, q_drive}, 32'd0);
    adv_n = 1'b0; wr_all_n = 1'b0; d_in = 32'hDEAD_0002; tick(); idle();
    chk("R10 still off", {31'd0, q_drive}, 32'd0);
    out_en_n = 1'b0;
    strb_ctl_n = 1'b0; a_in = 8'h12; tick(); idle();
    chk("R9 first read masked", {31'd0, q_drive}, 32'd0);
    tick();
    chk("R9 drive after mask", {31'd0, q_drive}, 32'd1);
    chk("R10 word 0x12 untouched", q_out, model[8'h12]);
    adv_n = 1'b0; tick(); idle();
    chk("R10 word 0x13 untouched", q_out, model[8'h13]);
  endtask

  bit done = 1'b0;

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_burst_wrap();
    t_suspend();
    t_bytes();
    t_cpu_strobe();
    t_enable_hold();
    t_oe();
    t_deselect_and_wake();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule